// File: doc/BRIEF.md
# Three-Bank Memory Router

This block owns three equal-depth byte-wide memory banks and a 3-bit configuration input that chooses how those banks are presented on three byte write ports (A, B, C) and three byte read ports. There are eight configurations: three separate channels, a three-line or two-line delay chain, two separate 12-bit channels, a 12-bit two-line chain, one channel three banks deep, one double-depth channel next to a normal one, and one double-depth 12-bit channel. Every channel is a circular line store. Each channel has a write pointer and a read pointer, and each pointer has a clear input. Deeper channels join banks by address: the pointer bits above the bank address select the bank. The 12-bit configurations join a full bank with one nibble half of bank B.

Each read port has a two-bit drive enable, one bit per nibble. A nibble is driven only in the cycle after its channel performed a read. In that cycle the nibble carries the word just read. Otherwise the pad is released. The configuration is treated as static. After a change, all pointers are cleared before the data means anything.

All control inputs are active high and sampled on the rising clock edge. A write occurs when a write enable is high and its write clear is low. A read occurs when a read enable is high and its read clear is low.

Top module: `bank_router`

## Requirements
- R1: The configuration code selects the following: 0 three channels, 1 three-bank chain, 2 two-bank chain plus channel C, 3 two 12-bit channels, 4 12-bit chain, 5 triple depth, 6 double depth on A plus channel C, 7 double-depth 12-bit.
- R2: In code 0, each port has its own channel of DEPTH bytes. Written words come back in write order. Read data and drive enable 2'b11 appear after the clock edge that performed the read.
- R3: When a write enable is low, nothing is stored and the write pointer holds, whatever the data input carries.
- R4: A clear sets its pointer to zero and wins over the enable. A read-clear cycle performs no read, so that port's drive enable is 2'b00 afterwards.
- R5: Pointers wrap to zero after the channel's last word. After DEPTH+1 writes, word 0 holds the newest word.
- R6: In code 3, channel 0 takes word bits 11:4 from byte A and bits 3:0 from byte B bits 3:0, using port A controls. Channel 1 takes bits 11:4 from byte C and bits 3:0 from byte B bits 7:4, using port B controls. The read side uses the same bit positions.
- R7: In code 1, a read on port A reads all three banks at one address. The old bank A word moves into bank B and the old bank B word moves into bank C. Port B therefore shows the word written DEPTH reads earlier, and port C the word written 2·DEPTH reads earlier.
- R8: In code 2, bank B delays port A by DEPTH reads, and channel C behaves as in code 0.
- R9: In code 4, a 12-bit word read on port A reappears DEPTH reads later: bits 11:4 on read byte C and bits 3:0 on read byte B bits 7:4.
- R10: In code 5, port A addresses 3·DEPTH bytes and wraps there.
- R11: In code 6, port A addresses 2·DEPTH bytes and wraps there, and port C is a separate DEPTH channel.
- R12: In code 7, port A is a 12-bit channel of 2·DEPTH words, mapped as channel 0 of R6.
- R13: A nibble's drive enable is low, and its data zero, unless its channel read in the previous cycle. The following nibbles are always released: read ports B and C in code 5, port B in code 6, and read byte C plus byte B bits 7:4 in code 7. Reset releases everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of pointers and drive enables |
| mode | input | 3 | Configuration code |
| wr_en_a | input | 1 | Write enable, port A |
| wr_rst_a | input | 1 | Write pointer clear, port A |
| wr_data_a | input | 8 | Write byte, port A |
| rd_en_a | input | 1 | Read enable, port A |
| rd_rst_a | input | 1 | Read pointer clear, port A |
| rd_data_a | output | 8 | Read byte, port A |
| rd_oe_a | output | 2 | Nibble drive enables, port A (bit 1 = bits 7:4) |
| wr_en_b | input | 1 | Write enable, port B |
| wr_rst_b | input | 1 | Write pointer clear, port B |
| wr_data_b | input | 8 | Write byte, port B |
| rd_en_b | input | 1 | Read enable, port B |
| rd_rst_b | input | 1 | Read pointer clear, port B |
| rd_data_b | output | 8 | Read byte, port B |
| rd_oe_b | output | 2 | Nibble drive enables, port B |
| wr_en_c | input | 1 | Write enable, port C |
| wr_rst_c | input | 1 | Write pointer clear, port C |
| wr_data_c | input | 8 | Write byte, port C |
| rd_en_c | input | 1 | Read enable, port C |
| rd_rst_c | input | 1 | Read pointer clear, port C |
| rd_data_c | output | 8 | Read byte, port C |
| rd_oe_c | output | 2 | Nibble drive enables, port C |

## Verification
The assertions check the following on every cycle:
- pad release for idle reads and for unused ports in the deep codes;
- that clears zero the port A pointers and silence its read byte;
- that the port A read pointer advances;
- that the write pointer wraps at the configured depth;
- that all three ports drive together in the three-bank chain.

Data integrity, however, needs the bench's scenarios, because checking it means remembering what was written lines earlier. This covers the bit placement of 12-bit words, the line delays of each chain, the bank joins of the deep codes and the overwrite on wrap.

// File: rtl/bank_router_pkg.sv
package bank_router_pkg;

   typedef enum logic [2:0] {
      CFG_TRIO  = 3'd0,
      CFG_CASC3 = 3'd1,
      CFG_CASC2 = 3'd2,
      CFG_WIDE2 = 3'd3,
      CFG_WCASC = 3'd4,
      CFG_DEEP3 = 3'd5,
      CFG_DEEP2 = 3'd6,
      CFG_WDEEP = 3'd7
   } cfg_e;

   localparam int NCHAN = 3;
   localparam int NLANE = 6;
   localparam int NIBW  = 4;

   // number of banks spanned by a channel in a configuration
   function automatic logic [1:0] depth_mult(cfg_e c, int ch);
      if (ch == 0) begin
         case (c)
            CFG_DEEP3:            return 2'd3;
            CFG_DEEP2, CFG_WDEEP: return 2'd2;
            default:              return 2'd1;
         endcase
      end
      return 2'd1;
   endfunction

endpackage

// File: rtl/bank_router_ptr.sv
module bank_router_ptr #(
   parameter int PW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_go,
   input  logic          wr_clr,
   input  logic          rd_go,
   input  logic          rd_clr,
   input  logic [PW-1:0] last,
   output logic [PW-1:0] wp,
   output logic [PW-1:0] rp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
      end else if (wr_clr) begin
         wp <= '0;
      end else if (wr_go) begin
         wp <= (wp == last) ? '0 : wp + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp <= '0;
      end else if (rd_clr) begin
         rp <= '0;
      end else if (rd_go) begin
         rp <= (rp == last) ? '0 : rp + 1'b1;
      end
   end

endmodule

// File: rtl/bank_router_lane.sv
module bank_router_lane #(
   parameter int DEPTH = 16,
   parameter int W     = 4
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [W-1:0]             wdata,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [W-1:0]             q,
   output logic [W-1:0]             peek
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) q <= mem[raddr];
   end

   // old word at the read address, used to feed the next line of a chain
   assign peek = mem[raddr];

endmodule

// File: rtl/bank_router_xbar.sv
module bank_router_xbar
   import bank_router_pkg::*;
#(
   parameter int AW = 4,
   parameter int PW = 6
) (
   input  cfg_e                 cfg,
   input  logic [2:0]           wr_go,
   input  logic [2:0]           rd_go,
   input  logic [2:0][PW-1:0]   wp,
   input  logic [2:0][PW-1:0]   rp,
   input  logic [2:0][7:0]      din,
   input  logic [5:0][3:0]      peek,
   output logic [5:0]           lane_we,
   output logic [5:0][AW-1:0]   lane_wa,
   output logic [5:0][3:0]      lane_wd,
   output logic [5:0]           lane_re,
   output logic [5:0][AW-1:0]   lane_ra,
   output logic [5:0][2:0]      out_src,
   output logic [5:0]           out_vld
);

   logic [23:0]     flat;
   logic [1:0]      wbank, rbank;
   logic [5:0][1:0] ctl;
   logic            unused_bits;

   assign flat  = din;
   assign wbank = wp[0][AW+1:AW];
   assign rbank = rp[0][AW+1:AW];
   assign unused_bits = ^{peek[5], peek[4], wp[1][PW-1:AW], wp[2][PW-1:AW],
                          rp[1][PW-1:AW], rp[2][PW-1:AW]};

   // controlling channel of each nibble lane for the non-deep layouts
   always_comb begin
      for (int l = 0; l < NLANE; l++) ctl[l] = 2'(l / 2);
      if (cfg == CFG_WIDE2 || cfg == CFG_WCASC) begin
         ctl[0] = 2'd0; ctl[1] = 2'd0; ctl[2] = 2'd0;
         ctl[3] = 2'd1; ctl[4] = 2'd1; ctl[5] = 2'd1;
      end
   end

   always_comb begin
      for (int l = 0; l < NLANE; l++) begin
         lane_we[l] = wr_go[ctl[l]];
         lane_wa[l] = wp[ctl[l]][AW-1:0];
         lane_wd[l] = flat[l*4 +: 4];
         lane_re[l] = rd_go[ctl[l]];
         lane_ra[l] = rp[ctl[l]][AW-1:0];
         out_src[l] = 3'(l);
         out_vld[l] = rd_go[ctl[l]];
      end
      case (cfg)
         CFG_CASC3, CFG_CASC2: begin
            for (int l = 2; l < NLANE; l++) begin
               if (cfg == CFG_CASC3 || l < 4) begin
                  lane_we[l] = rd_go[0];
                  lane_wa[l] = rp[0][AW-1:0];
                  lane_wd[l] = peek[l-2];
                  lane_re[l] = rd_go[0];
                  lane_ra[l] = rp[0][AW-1:0];
                  out_vld[l] = rd_go[0];
               end
            end
         end
         CFG_WCASC: begin
            for (int j = 0; j < 3; j++) begin
               lane_we[(j == 2) ? 3 : 4 + j] = rd_go[0];
               lane_wa[(j == 2) ? 3 : 4 + j] = rp[0][AW-1:0];
               lane_wd[(j == 2) ? 3 : 4 + j] = peek[j];
               lane_re[(j == 2) ? 3 : 4 + j] = rd_go[0];
               lane_ra[(j == 2) ? 3 : 4 + j] = rp[0][AW-1:0];
               out_vld[(j == 2) ? 3 : 4 + j] = rd_go[0];
            end
         end
         CFG_DEEP3, CFG_DEEP2: begin
            for (int l = 0; l < NLANE; l++) begin
               if (cfg == CFG_DEEP3 || l < 4) begin
                  lane_we[l] = wr_go[0] && (wbank == 2'(l / 2));
                  lane_wa[l] = wp[0][AW-1:0];
                  lane_wd[l] = flat[(l % 2)*4 +: 4];
                  lane_re[l] = rd_go[0] && (rbank == 2'(l / 2));
                  lane_ra[l] = rp[0][AW-1:0];
               end
            end
            out_src[0] = {rbank, 1'b0};
            out_src[1] = {rbank, 1'b1};
            out_vld[0] = rd_go[0];
            out_vld[1] = rd_go[0];
            out_vld[2] = 1'b0;
            out_vld[3] = 1'b0;
            if (cfg == CFG_DEEP3) begin
               out_vld[4] = 1'b0;
               out_vld[5] = 1'b0;
            end
         end
         CFG_WDEEP: begin
            for (int l = 0; l < NLANE; l++) begin
               lane_wa[l] = wp[0][AW-1:0];
               lane_ra[l] = rp[0][AW-1:0];
            end
            lane_we[0] = wr_go[0] && !wbank[0];
            lane_we[1] = wr_go[0] && !wbank[0];
            lane_we[2] = wr_go[0] && !wbank[0];
            lane_we[3] = wr_go[0] &&  wbank[0];
            lane_we[4] = wr_go[0] &&  wbank[0];
            lane_we[5] = wr_go[0] &&  wbank[0];
            lane_re[0] = rd_go[0] && !rbank[0];
            lane_re[1] = rd_go[0] && !rbank[0];
            lane_re[2] = rd_go[0] && !rbank[0];
            lane_re[3] = rd_go[0] &&  rbank[0];
            lane_re[4] = rd_go[0] &&  rbank[0];
            lane_re[5] = rd_go[0] &&  rbank[0];
            lane_wd[0] = flat[3:0];
            lane_wd[1] = flat[7:4];
            lane_wd[2] = flat[11:8];
            lane_wd[3] = flat[11:8];
            lane_wd[4] = flat[3:0];
            lane_wd[5] = flat[7:4];
            out_src[0] = rbank[0] ? 3'd4 : 3'd0;
            out_src[1] = rbank[0] ? 3'd5 : 3'd1;
            out_src[2] = rbank[0] ? 3'd3 : 3'd2;
            out_vld[0] = rd_go[0];
            out_vld[1] = rd_go[0];
            out_vld[2] = rd_go[0];
            out_vld[3] = 1'b0;
            out_vld[4] = 1'b0;
            out_vld[5] = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bank_router.sv
module bank_router
   import bank_router_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  logic       wr_en_a,
   input  logic       wr_rst_a,
   input  logic [7:0] wr_data_a,
   input  logic       rd_en_a,
   input  logic       rd_rst_a,
   output logic [7:0] rd_data_a,
   output logic [1:0] rd_oe_a,
   input  logic       wr_en_b,
   input  logic       wr_rst_b,
   input  logic [7:0] wr_data_b,
   input  logic       rd_en_b,
   input  logic       rd_rst_b,
   output logic [7:0] rd_data_b,
   output logic [1:0] rd_oe_b,
   input  logic       wr_en_c,
   input  logic       wr_rst_c,
   input  logic [7:0] wr_data_c,
   input  logic       rd_en_c,
   input  logic       rd_rst_c,
   output logic [7:0] rd_data_c,
   output logic [1:0] rd_oe_c
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 2;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bank_router: DEPTH must be a power of two of at least 2");
   end

   cfg_e                  cfg;
   logic [2:0]            wr_en, wr_clr, rd_en, rd_clr, wr_go, rd_go;
   logic [2:0][7:0]       din;
   logic [2:0][PW-1:0]    wp_q, rp_q, last;
   logic [5:0]            lane_we, lane_re, out_vld, oe_q;
   logic [5:0][AW-1:0]    lane_wa, lane_ra;
   logic [5:0][3:0]       lane_wd, lane_q, lane_peek, nib;
   logic [5:0][2:0]       out_src, sel_q;

   assign cfg    = cfg_e'(mode);
   assign wr_en  = {wr_en_c,  wr_en_b,  wr_en_a};
   assign wr_clr = {wr_rst_c, wr_rst_b, wr_rst_a};
   assign rd_en  = {rd_en_c,  rd_en_b,  rd_en_a};
   assign rd_clr = {rd_rst_c, rd_rst_b, rd_rst_a};
   assign din    = {wr_data_c, wr_data_b, wr_data_a};
   assign wr_go  = wr_en & ~wr_clr;
   assign rd_go  = rd_en & ~rd_clr;

   always_comb begin
      for (int i = 0; i < NCHAN; i++)
         last[i] = PW'(DEPTH * int'(depth_mult(cfg, i)) - 1);
   end

   for (genvar i = 0; i < NCHAN; i++) begin : g_ptr
      bank_router_ptr #(.PW(PW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_go  (wr_go[i]),
         .wr_clr (wr_clr[i]),
         .rd_go  (rd_go[i]),
         .rd_clr (rd_clr[i]),
         .last   (last[i]),
         .wp     (wp_q[i]),
         .rp     (rp_q[i])
      );
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      bank_router_lane #(.DEPTH(DEPTH), .W(NIBW)) u_lane (
         .clk   (clk),
         .we    (lane_we[l]),
         .waddr (lane_wa[l]),
         .wdata (lane_wd[l]),
         .re    (lane_re[l]),
         .raddr (lane_ra[l]),
         .q     (lane_q[l]),
         .peek  (lane_peek[l])
      );
   end

   bank_router_xbar #(.AW(AW), .PW(PW)) u_xbar (
      .cfg     (cfg),
      .wr_go   (wr_go),
      .rd_go   (rd_go),
      .wp      (wp_q),
      .rp      (rp_q),
      .din     (din),
      .peek    (lane_peek),
      .lane_we (lane_we),
      .lane_wa (lane_wa),
      .lane_wd (lane_wd),
      .lane_re (lane_re),
      .lane_ra (lane_ra),
      .out_src (out_src),
      .out_vld (out_vld)
   );

   // output nibble source and drive enable follow the lane registers by the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         oe_q  <= '0;
      end else begin
         sel_q <= out_src;
         oe_q  <= out_vld;
      end
   end

   always_comb begin
      for (int o = 0; o < NLANE; o++)
         nib[o] = oe_q[o] ? lane_q[sel_q[o]] : 4'h0;
   end

   assign rd_data_a = {nib[1], nib[0]};
   assign rd_data_b = {nib[3], nib[2]};
   assign rd_data_c = {nib[5], nib[4]};
   assign rd_oe_a   = oe_q[1:0];
   assign rd_oe_b   = oe_q[3:2];
   assign rd_oe_c   = oe_q[5:4];

endmodule

// File: rtl/bank_router_chk.sv
module bank_router_chk #(
   parameter int PW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    mode,
   input logic          wr_en_a,
   input logic          wr_rst_a,
   input logic          rd_en_a,
   input logic          rd_rst_a,
   input logic          rd_en_b,
   input logic          rd_en_c,
   input logic [1:0]    rd_oe_a,
   input logic [1:0]    rd_oe_b,
   input logic [1:0]    rd_oe_c,
   input logic [PW-1:0] wp0,
   input logic [PW-1:0] rp0,
   input logic [PW-1:0] last0
);

   AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en_a && !rd_en_b && !rd_en_c) |=> (rd_oe_a == 2'b00 && rd_oe_b == 2'b00 && rd_oe_c == 2'b00)); // R13

   AST_DEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd5 || mode == 3'd7) |=> (rd_oe_b[1] == 1'b0 && rd_oe_c == 2'b00)); // R13

   AST_DEEP2_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd6) |=> (rd_oe_b == 2'b00)); // R13

   AST_WCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst_a |=> (wp0 == '0)); // R4

   AST_RCLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rst_a |=> (rd_oe_a == 2'b00 && rp0 == '0)); // R4

   AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_a && !rd_rst_a) |=> (rp0 != $past(rp0))); // R2

   AST_WR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_a && !wr_rst_a && wp0 == last0) |=> (wp0 == '0)); // R5

   AST_CHAIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1 && rd_en_a && !rd_rst_a) |=> (rd_oe_a == 2'b11 && rd_oe_b == 2'b11 && rd_oe_c == 2'b11)); // R7

endmodule

bind bank_router bank_router_chk #(.PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .wr_en_a  (wr_en_a),
   .wr_rst_a (wr_rst_a),
   .rd_en_a  (rd_en_a),
   .rd_rst_a (rd_rst_a),
   .rd_en_b  (rd_en_b),
   .rd_en_c  (rd_en_c),
   .rd_oe_a  (rd_oe_a),
   .rd_oe_b  (rd_oe_b),
   .rd_oe_c  (rd_oe_c),
   .wp0      (wp_q[0]),
   .rp0      (rp_q[0]),
   .last0    (last[0])
);

// File: tb/bank_router_tb.sv
module bank_router_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      mode = 3'd0;
   logic [2:0]      we = '0, wrs = '0, re = '0, rrs = '0;
   logic [2:0][7:0] wd = '0;
   logic [7:0]      rq [3];
   logic [1:0]      oe [3];

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_router #(.DEPTH(DEPTH)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .wr_en_a   (we[0]), .wr_rst_a (wrs[0]), .wr_data_a (wd[0]),
      .rd_en_a   (re[0]), .rd_rst_a (rrs[0]), .rd_data_a (rq[0]), .rd_oe_a (oe[0]),
      .wr_en_b   (we[1]), .wr_rst_b (wrs[1]), .wr_data_b (wd[1]),
      .rd_en_b   (re[1]), .rd_rst_b (rrs[1]), .rd_data_b (rq[1]), .rd_oe_b (oe[1]),
      .wr_en_c   (we[2]), .wr_rst_c (wrs[2]), .wr_data_c (wd[2]),
      .rd_en_c   (re[2]), .rd_rst_c (rrs[2]), .rd_data_c (rq[2]), .rd_oe_c (oe[2])
   );

   function automatic logic [7:0] v8(int seed, int k);
      return 8'(seed * 37 + k * 13 + 5);
   endfunction

   function automatic logic [11:0] v12(int seed, int k);
      return 12'(seed * 291 + k * 77 + 9);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic setup(input logic [2:0] m);
      mode = m; we = '0; re = '0; wd = '0;
      wrs = 3'b111; rrs = 3'b111;
      tick();
      wrs = '0; rrs = '0;
   endtask

   task automatic t_reset();
      chk("R13 reset oe a", 32'(oe[0]), 0);
      chk("R13 reset oe b", 32'(oe[1]), 0);
      chk("R13 reset oe c", 32'(oe[2]), 0);
      chk("R13 reset data b", 32'(rq[1]), 0);
   endtask

   task automatic t_trio();
      setup(3'd0);
      we = 3'b111;
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 3; i++) wd[i] = v8(i, k);
         tick();
      end
      we = '0;
      re = 3'b111;
      for (int k = 0; k < 4; k++) begin
         tick();
         for (int i = 0; i < 3; i++) begin
            chk("R1/R2 trio data", 32'(rq[i]), 32'(v8(i, k)));
            chk("R2 trio oe", 32'(oe[i]), 3);
         end
      end
      re = '0;
      tick();
      chk("R13 idle releases a", 32'(oe[0]), 0);
   endtask

   task automatic t_wr_hold();
      setup(3'd0);
      wd[0] = v8(9, 0); we[0] = 1'b1; tick();
      we[0] = 1'b0; wd[0] = 8'hEE; tick(); tick();
      wd[0] = v8(9, 1); we[0] = 1'b1; tick();
      we[0] = 1'b0;
      re[0] = 1'b1;
      tick(); chk("R3 hold word0", 32'(rq[0]), 32'(v8(9, 0)));
      tick(); chk("R3 hold word1", 32'(rq[0]), 32'(v8(9, 1)));
      re[0] = 1'b0;
   endtask

   task automatic t_clear_prio();
      setup(3'd0);
      we[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin wd[0] = v8(11, k); tick(); end
      we[0] = 1'b0;
      re[0] = 1'b1;
      tick(); chk("R4 pre word0", 32'(rq[0]), 32'(v8(11, 0)));
      tick(); chk("R4 pre word1", 32'(rq[0]), 32'(v8(11, 1)));
      rrs[0] = 1'b1;
      tick(); chk("R4 clear no read", 32'(oe[0]), 0);
      rrs[0] = 1'b0;
      tick(); chk("R4 restart word0", 32'(rq[0]), 32'(v8(11, 0)));
      re[0] = 1'b0;
   endtask

   task automatic t_wrap();
      setup(3'd0);
      we[1] = 1'b1;
      for (int k = 0; k <= DEPTH; k++) begin wd[1] = v8(4, k); tick(); end
      we[1] = 1'b0;
      re[1] = 1'b1;
      tick(); chk("R5 wrap overwrote word0", 32'(rq[1]), 32'(v8(4, DEPTH)));
      tick(); chk("R5 wrap word1", 32'(rq[1]), 32'(v8(4, 1)));
      re[1] = 1'b0;
   endtask

   task automatic t_wide();
      logic [11:0] w0, w1;
      setup(3'd3);
      we = 3'b011;
      for (int k = 0; k < 3; k++) begin
         w0 = v12(1, k); w1 = v12(2, k);
         wd[0] = w0[11:4]; wd[2] = w1[11:4]; wd[1] = {w1[3:0], w0[3:0]};
         tick();
      end
      we = '0;
      re = 3'b001; tick();
      w0 = v12(1, 0);
      chk("R6 ch0 hi byte", 32'(rq[0]), 32'(w0[11:4]));
      chk("R6 ch0 lo nibble", 32'(rq[1][3:0]), 32'(w0[3:0]));
      chk("R6 ch0 oe b", 32'(oe[1]), 1);
      chk("R13 ch1 idle oe c", 32'(oe[2]), 0);
      chk("R13 ch1 idle nibble zero", 32'(rq[1][7:4]), 0);
      re = 3'b010; tick();
      w1 = v12(2, 0);
      chk("R6 ch1 hi byte", 32'(rq[2]), 32'(w1[11:4]));
      chk("R6 ch1 lo nibble", 32'(rq[1][7:4]), 32'(w1[3:0]));
      chk("R6 ch1 oe b", 32'(oe[1]), 2);
      re = 3'b011;
      for (int k = 1; k < 3; k++) begin
         tick();
         w0 = v12(1, k); w1 = v12(2, k);
         chk("R6 both ch0", 32'({rq[0], rq[1][3:0]}), 32'(w0));
         chk("R6 both ch1", 32'({rq[2], rq[1][7:4]}), 32'(w1));
      end
      re = '0;
   endtask

   task automatic t_casc3();
      setup(3'd1);
      we[0] = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin wd[0] = v8(1, k); tick(); end
      we[0] = 1'b0;
      re[0] = 1'b1;
      for (int c = 0; c < 3*DEPTH; c++) begin
         tick();
         chk("R7 chain line0", 32'(rq[0]), 32'(v8(1, c % DEPTH)));
         if (c >= DEPTH)   chk("R7 chain line1", 32'(rq[1]), 32'(v8(1, c % DEPTH)));
         if (c >= 2*DEPTH) chk("R7 chain line2", 32'(rq[2]), 32'(v8(1, c % DEPTH)));
      end
      re[0] = 1'b0;
   endtask

   task automatic t_casc2();
      setup(3'd2);
      we = 3'b101;
      for (int k = 0; k < DEPTH; k++) begin wd[0] = v8(2, k); wd[2] = v8(3, k); tick(); end
      we = '0;
      re = 3'b101;
      for (int c = 0; c < 2*DEPTH; c++) begin
         tick();
         chk("R8 line0", 32'(rq[0]), 32'(v8(2, c % DEPTH)));
         if (c >= DEPTH) chk("R8 line1", 32'(rq[1]), 32'(v8(2, c % DEPTH)));
         else            chk("R8 channel C", 32'(rq[2]), 32'(v8(3, c)));
         if (c == DEPTH - 1) re[2] = 1'b0;
      end
      re = '0;
   endtask

   task automatic t_wcasc();
      logic [11:0] w;
      setup(3'd4);
      we[0] = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
         w = v12(3, k); wd[0] = w[11:4]; wd[1] = {4'h0, w[3:0]}; tick();
      end
      we[0] = 1'b0;
      re[0] = 1'b1;
      for (int c = 0; c < 2*DEPTH; c++) begin
         tick();
         w = v12(3, c % DEPTH);
         chk("R9 line0", 32'({rq[0], rq[1][3:0]}), 32'(w));
         if (c >= DEPTH) chk("R9 line1", 32'({rq[2], rq[1][7:4]}), 32'(w));
      end
      re[0] = 1'b0;
   endtask

   task automatic t_deep3();
      setup(3'd5);
      we[0] = 1'b1;
      for (int k = 0; k < 3*DEPTH; k++) begin wd[0] = v8(5, k); tick(); end
      we[0] = 1'b0;
      re[0] = 1'b1;
      for (int c = 0; c <= 3*DEPTH; c++) begin
         tick();
         chk("R1/R10 triple depth", 32'(rq[0]), 32'(v8(5, c % (3*DEPTH))));
         chk("R13 triple oe b", 32'(oe[1]), 0);
         chk("R13 triple oe c", 32'(oe[2]), 0);
      end
      re[0] = 1'b0;
   endtask

   task automatic t_deep2();
      setup(3'd6);
      we = 3'b101;
      for (int k = 0; k < 2*DEPTH; k++) begin
         wd[0] = v8(6, k); wd[2] = v8(7, k);
         if (k == DEPTH) we[2] = 1'b0;
         tick();
      end
      we = '0;
      re = 3'b101;
      for (int c = 0; c <= 2*DEPTH; c++) begin
         tick();
         chk("R11 double depth", 32'(rq[0]), 32'(v8(6, c % (2*DEPTH))));
         chk("R13 double oe b", 32'(oe[1]), 0);
         if (c < DEPTH) chk("R11 channel C", 32'(rq[2]), 32'(v8(7, c)));
         if (c == DEPTH - 1) re[2] = 1'b0;
      end
      re = '0;
   endtask

   task automatic t_wdeep();
      logic [11:0] w;
      setup(3'd7);
      we[0] = 1'b1;
      for (int k = 0; k < 2*DEPTH; k++) begin
         w = v12(8, k); wd[0] = w[11:4]; wd[1] = {4'hA, w[3:0]}; tick();
      end
      we[0] = 1'b0;
      re[0] = 1'b1;
      for (int c = 0; c < 2*DEPTH; c++) begin
         tick();
         chk("R12 wide deep", 32'({rq[0], rq[1][3:0]}), 32'(v12(8, c)));
         chk("R13 wide deep oe b", 32'(oe[1]), 1);
         chk("R13 wide deep oe c", 32'(oe[2]), 0);
      end
      re[0] = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      tick();
      t_trio();
      t_wr_hold();
      t_clear_prio();
      t_wrap();
      t_wide();
      t_casc3();
      t_casc2();
      t_wcasc();
      t_deep3();
      t_deep2();
      t_wdeep();
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule